// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block picks the program counter value that follows a control-flow instruction in a small microcontroller core. It receives the current PC, a decoded control-flow code, a signed relative offset, the eight-bit status register, a bit-select index, the value of an already selected register or I/O bit, an equality result from the compare path, the 16-bit Z pointer, a 6-bit extended-address value, and a flag that says whether the instruction after the current one is two words long.

It produces the next PC, a taken indication and the cycle cost of the instruction. All three outputs are registered, so they reflect the inputs sampled at the previous rising clock edge. The following control-flow types are covered:

- relative jump
- indirect jump through Z
- extended indirect jump that adds the extended-address bits above Z
- conditional branch on any status bit, either set or clear
- conditional skip of the next instruction, on equality or on a chosen bit being clear or set

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst_n` is low, the outputs hold `next_pc`=0, `taken`=0 and `cycles`=1.
- R2: Code 0 and the unused codes 9 to 15 give `next_pc` = PC+1, not taken, 1 cycle.
- R3: Code 1 (relative jump) gives `next_pc` = PC + sign-extended `rel_ofs` + 1, taken, 2 cycles.
- R4: Code 2 (indirect jump) gives `next_pc` = `zptr` zero-extended to 22 bits, taken, 2 cycles.
- R5: Code 3 (extended indirect jump) gives `next_pc[15:0]` = `zptr` and `next_pc[21:16]` = `ext_addr`, taken, 2 cycles.
- R6: Code 4 branches when `sreg[bit_sel]` is 1. Code 5 branches when `sreg[bit_sel]` is 0. A taken branch gives PC + sign-extended `rel_ofs` + 1 and costs 2 cycles.
- R7: `bit_sel` can pick any of the 8 status bits. For example, branch-if-same-or-higher is code 5 with `bit_sel`=0 (carry), and signed-less-than is code 4 with `bit_sel`=4 (sign).
- R8: A branch whose condition fails gives PC+1, not taken, 1 cycle.
- R9: Codes 6, 7 and 8 skip when, respectively, `cmp_eq`=1, `test_bit`=0 or `test_bit`=1. A skip gives PC+2 and 2 cycles when `next_two_word`=0, and PC+3 and 3 cycles when `next_two_word`=1.
- R10: A skip whose condition fails gives PC+1, not taken, 1 cycle, whatever the value of `next_two_word`.
- R11: Every PC sum wraps modulo 2^22.
- R12: The outputs change only on a rising clock edge, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 22 | Address of the current instruction |
| cf_op | input | 4 | Control-flow code (see R2 to R9) |
| rel_ofs | input | 12 | Signed relative offset, in words |
| sreg | input | 8 | Status register |
| bit_sel | input | 3 | Status bit index tested by a branch |
| test_bit | input | 1 | Selected register or I/O bit tested by a bit skip |
| cmp_eq | input | 1 | Equality result for compare-and-skip |
| zptr | input | 16 | Z pointer |
| ext_addr | input | 6 | Upper PC bits for the extended indirect jump |
| next_two_word | input | 1 | The following instruction is two words long |
| next_pc | output | 22 | Chosen next PC |
| taken | output | 1 | The flow left the sequential path |
| cycles | output | 2 | Cycle cost of the instruction (1 to 3) |

## Verification
The bench sweeps all eight status bits with both branch senses. A unit that used the wrong bit, or the wrong polarity, would send a branch to the offset target when it should fall through. Skips are driven with and without a two-word successor, including failing skips that carry the two-word flag. A unit that added 3 without the skip condition, or charged 3 cycles there, would be caught. Offsets at both sign extremes and PCs near the top of the 22-bit space expose a missing sign extension or a carry that leaks past bit 21. The extended indirect jump is run with a nonzero upper part, so that a unit dropping `ext_addr` returns a short address.

// File: rtl/branch_skip_unit.sv
module branch_skip_unit #(
  parameter int PC_W  = 22,
  parameter int OFS_W = 12,
  parameter int Z_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [3:0]           cf_op,
  input  logic [OFS_W-1:0]     rel_ofs,
  input  logic [7:0]           sreg,
  input  logic [2:0]           bit_sel,
  input  logic                 test_bit,
  input  logic                 cmp_eq,
  input  logic [Z_W-1:0]       zptr,
  input  logic [PC_W-Z_W-1:0]  ext_addr,
  input  logic                 next_two_word,
  output logic [PC_W-1:0]      next_pc,
  output logic                 taken,
  output logic [1:0]           cycles
);
  localparam int EXT_W = PC_W - Z_W;
  localparam logic [3:0] OP_RJMP = 4'd1, OP_IJMP = 4'd2, OP_EIJMP = 4'd3,
                         OP_BSET = 4'd4, OP_BCLR = 4'd5, OP_SKEQ = 4'd6,
                         OP_SKBC = 4'd7, OP_SKBS = 4'd8;

  logic [PC_W-1:0] ofs_ext, pc_seq, pc_rel, pc_skip, pc_d;
  logic            flag, br_hit, sk_hit, tk_d;
  logic [1:0]      cy_d;

  assign ofs_ext = {{(PC_W-OFS_W){rel_ofs[OFS_W-1]}}, rel_ofs};
  assign pc_seq  = pc_i + PC_W'(1);
  assign pc_rel  = pc_seq + ofs_ext;
  assign pc_skip = pc_i + (next_two_word ? PC_W'(3) : PC_W'(2));
  assign flag    = sreg[bit_sel];
  assign br_hit  = (cf_op == OP_BSET && flag) || (cf_op == OP_BCLR && !flag);
  assign sk_hit  = (cf_op == OP_SKEQ && cmp_eq) || (cf_op == OP_SKBC && !test_bit) ||
                   (cf_op == OP_SKBS && test_bit);

  always_comb begin
    pc_d = pc_seq;
    tk_d = 1'b0;
    cy_d = 2'd1;
    case (cf_op)
      OP_RJMP:  begin pc_d = pc_rel; tk_d = 1'b1; cy_d = 2'd2; end
      OP_IJMP:  begin pc_d = {{EXT_W{1'b0}}, zptr}; tk_d = 1'b1; cy_d = 2'd2; end
      OP_EIJMP: begin pc_d = {ext_addr, zptr}; tk_d = 1'b1; cy_d = 2'd2; end
      OP_BSET, OP_BCLR:
        if (br_hit) begin pc_d = pc_rel; tk_d = 1'b1; cy_d = 2'd2; end
      OP_SKEQ, OP_SKBC, OP_SKBS:
        if (sk_hit) begin
          pc_d = pc_skip;
          tk_d = 1'b1;
          cy_d = next_two_word ? 2'd3 : 2'd2;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc <= '0;
      taken   <= 1'b0;
      cycles  <= 2'd1;
    end else begin
      next_pc <= pc_d;
      taken   <= tk_d;
      cycles  <= cy_d;
    end
  end
endmodule

// File: rtl/branch_skip_unit_chk.sv
module branch_skip_unit_chk #(
  parameter int PC_W = 22,
  parameter int Z_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PC_W-1:0]     pc_i,
  input logic [3:0]          cf_op,
  input logic [7:0]          sreg,
  input logic [2:0]          bit_sel,
  input logic                test_bit,
  input logic                next_two_word,
  input logic [Z_W-1:0]      zptr,
  input logic [PC_W-Z_W-1:0] ext_addr,
  input logic [PC_W-1:0]     next_pc,
  input logic                taken,
  input logic [1:0]          cycles
);
  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> next_pc == '0 && !taken && cycles == 2'd1); // R1
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cf_op == 4'd0 |=> !taken && cycles == 2'd1 && next_pc == $past(pc_i) + PC_W'(1)); // R2
  AST_JUMP_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_op == 4'd1 || cf_op == 4'd2 || cf_op == 4'd3) |=> taken && cycles == 2'd2); // R3
  AST_IND_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cf_op == 4'd2 |=> next_pc == PC_W'($past(zptr))); // R4
  AST_EXT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cf_op == 4'd3 |=> next_pc == {$past(ext_addr), $past(zptr)}); // R5
  AST_BRANCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_op == 4'd4 && sreg[bit_sel]) |=> taken && cycles == 2'd2); // R6
  AST_BRANCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cf_op == 4'd4 && !sreg[bit_sel]) || (cf_op == 4'd5 && sreg[bit_sel])) |=>
      !taken && cycles == 2'd1 && next_pc == $past(pc_i) + PC_W'(1)); // R8
  AST_SKIP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_op == 4'd8 && test_bit && next_two_word) |=>
      taken && cycles == 2'd3 && next_pc == $past(pc_i) + PC_W'(3)); // R9
  AST_SKIP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_op == 4'd7 && test_bit) |=> !taken && cycles == 2'd1); // R10
  AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
    taken == (cycles != 2'd1) && cycles != 2'd0); // R12
endmodule

bind branch_skip_unit branch_skip_unit_chk #(.PC_W(PC_W), .Z_W(Z_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .cf_op(cf_op), .sreg(sreg),
  .bit_sel(bit_sel), .test_bit(test_bit), .next_two_word(next_two_word),
  .zptr(zptr), .ext_addr(ext_addr), .next_pc(next_pc), .taken(taken),
  .cycles(cycles));

// File: tb/sim_branch_skip_unit.sv
module sim_branch_skip_unit;
  localparam int PC_W = 22, OFS_W = 12, Z_W = 16, EXT_W = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [PC_W-1:0] pc_i;
  logic [3:0] cf_op;
  logic [OFS_W-1:0] rel_ofs;
  logic [7:0] sreg;
  logic [2:0] bit_sel;
  logic test_bit, cmp_eq, next_two_word;
  logic [Z_W-1:0] zptr;
  logic [EXT_W-1:0] ext_addr;
  logic [PC_W-1:0] next_pc;
  logic taken;
  logic [1:0] cycles;

  int tests = 0, fails = 0;
  longint e_pc;
  int e_tk, e_cy;
  string e_req;

  branch_skip_unit u0 (.clk(clk), .rst_n(rst_n), .pc_i(pc_i), .cf_op(cf_op),
    .rel_ofs(rel_ofs), .sreg(sreg), .bit_sel(bit_sel), .test_bit(test_bit),
    .cmp_eq(cmp_eq), .zptr(zptr), .ext_addr(ext_addr),
    .next_two_word(next_two_word), .next_pc(next_pc), .taken(taken),
    .cycles(cycles));

  function automatic longint wrap(longint v);
    longint m = longint'(1) << PC_W;
    return ((v % m) + m) % m;
  endfunction

  task automatic model(string tag);
    longint p = longint'(pc_i);
    longint k = longint'($signed(rel_ofs));
    int op = int'(cf_op);
    bit cond;
    e_pc = wrap(p + 1); e_tk = 0; e_cy = 1; e_req = "R2";
    if (op == 1) begin e_pc = wrap(p + k + 1); e_tk = 1; e_cy = 2; e_req = "R3"; end
    else if (op == 2) begin e_pc = longint'(zptr); e_tk = 1; e_cy = 2; e_req = "R4"; end
    else if (op == 3) begin
      e_pc = longint'(ext_addr) * 65536 + longint'(zptr); e_tk = 1; e_cy = 2; e_req = "R5";
    end else if (op == 4 || op == 5) begin
      cond = (op == 4) ? sreg[bit_sel] : !sreg[bit_sel];
      if (cond) begin e_pc = wrap(p + k + 1); e_tk = 1; e_cy = 2; e_req = "R6"; end
      else e_req = "R8";
    end else if (op >= 6 && op <= 8) begin
      cond = (op == 6) ? cmp_eq : (op == 7) ? !test_bit : test_bit;
      if (cond) begin
        e_tk = 1;
        e_cy = next_two_word ? 3 : 2;
        e_pc = wrap(p + e_cy);
        e_req = "R9";
      end else e_req = "R10";
    end
    if (tag != "") e_req = tag;
  endtask

  task automatic check();
    tests++;
    if (longint'(next_pc) != e_pc || int'(taken) != e_tk || int'(cycles) != e_cy) begin
      fails++;
      $display("FAIL %s: got pc=%h tk=%0d cy=%0d, expected pc=%h tk=%0d cy=%0d",
               e_req, next_pc, taken, cycles, e_pc, e_tk, e_cy);
    end
  endtask

  task automatic apply(string tag, int op, longint pc, int ofs, int sr, int sel,
                       bit tb, bit eq, int z, int ext, bit tw);
    @(negedge clk);
    cf_op = 4'(op); pc_i = PC_W'(pc); rel_ofs = OFS_W'(ofs); sreg = 8'(sr);
    bit_sel = 3'(sel); test_bit = tb; cmp_eq = eq; zptr = Z_W'(z);
    ext_addr = EXT_W'(ext); next_two_word = tw;
    model(tag);
    @(negedge clk);
    check();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cf_op = 4'd1; pc_i = 22'h1234; rel_ofs = 12'd5; sreg = 8'hFF;
    bit_sel = 3'd0; test_bit = 1'b1; cmp_eq = 1'b1; zptr = 16'hBEEF;
    ext_addr = 6'h3F; next_two_word = 1'b1;
    repeat (3) @(negedge clk);
    e_pc = 0; e_tk = 0; e_cy = 1; e_req = "R1";
    check();
    rst_n = 1'b1;

    apply("", 0, 22'h000100, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int op = 9; op < 16; op++) apply("", op, 22'h00ABCD, 7, 8'hFF, 1, 1, 1, 1, 1, 1);
    apply("", 1, 22'h001000, 2047, 0, 0, 0, 0, 0, 0, 0);
    apply("", 1, 22'h001000, -2048, 0, 0, 0, 0, 0, 0, 0);
    apply("", 1, 22'h000010, -1, 0, 0, 0, 0, 0, 0, 0);
    apply("R11", 1, 22'h3FFFF0, 100, 0, 0, 0, 0, 0, 0, 0);
    apply("R11", 1, 22'h000002, -10, 0, 0, 0, 0, 0, 0, 0);
    apply("R11", 0, 22'h3FFFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R11", 8, 22'h3FFFFE, 0, 0, 0, 1, 0, 0, 0, 1);
    apply("", 2, 22'h2AAAAA, 0, 0, 0, 0, 0, 16'hFFFF, 6'h15, 0);
    apply("", 3, 22'h000001, 0, 0, 0, 0, 0, 16'h1234, 6'h2A, 0);
    apply("", 3, 22'h000001, 0, 0, 0, 0, 0, 16'h0000, 6'h3F, 0);
    for (int s = 0; s < 8; s++) begin
      apply("R7", 4, 22'h000400, -3, 1 << s, s, 0, 0, 0, 0, 0);
      apply("R7", 4, 22'h000400, -3, ~(1 << s), s, 0, 0, 0, 0, 0);
      apply("R7", 5, 22'h000400, 9, ~(1 << s), s, 0, 0, 0, 0, 0);
      apply("R7", 5, 22'h000400, 9, 1 << s, s, 0, 0, 0, 0, 0);
    end
    apply("R7", 5, 22'h000050, 4, 8'hFE, 0, 0, 0, 0, 0, 0);
    apply("R7", 4, 22'h000050, 4, 8'h10, 4, 0, 0, 0, 0, 0);
    apply("", 6, 22'h000200, 0, 0, 0, 0, 1, 0, 0, 0);
    apply("", 6, 22'h000200, 0, 0, 0, 0, 1, 0, 0, 1);
    apply("", 6, 22'h000200, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("", 7, 22'h000300, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("", 7, 22'h000300, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("", 7, 22'h000300, 0, 0, 0, 1, 0, 0, 0, 1);
    apply("", 8, 22'h000300, 0, 0, 0, 1, 0, 0, 0, 0);
    apply("", 8, 22'h000300, 0, 0, 0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 400; i++)
      apply((i % 2) ? "R12" : "", int'($urandom_range(0, 15)), longint'($urandom),
            int'($urandom), int'($urandom), int'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom), int'($urandom), 1'($urandom));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    e_pc = 0; e_tk = 0; e_cy = 1; e_req = "R1";
    check();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule